// File: doc/BRIEF.md
# Buck Converter Start-Up and Hiccup Protection Sequencer

This block is the digital supervisor of a peak-current-mode step-down regulator. It runs on the system clock and also sees a single-cycle strobe once per switching period. It starts the converter with a soft-start ramp, and it decides from a set of digital comparator flags when the modulator and the two gate drivers may run. The ramp is a counter that the reference path follows. It climbs five units per switching period during a normal start. It reaches the regulation point after `STEPS` periods and then rises further to a saturation level, where a start-complete flag asserts.

Faults are handled by tier. A light overcurrent only raises a per-cycle limit toward the modulator. A severe overcurrent lets two more switching periods pass, then blanks PWM and runs a slow dummy ramp at one unit per period, which takes five times as long as a normal start. A fresh normal start follows. If the severe overcurrent comes back, the hiccup repeats. A mild overvoltage turns both drivers off until feedback drops back to the reference. A severe overvoltage latches the block off until an explicit unlatch. Over-temperature stops switching until the cool-down flag is seen. Loss of enable or of the supply-good flag sends the block back to idle from every state except the overvoltage latch.

Top module: `hiccup_seq`

## Requirements
- R1: After a clock edge with `rst` high, `ss_ramp` is 0 and `pwm_en`, `hs_en`, `ls_en`, `ss_done` and `cbc_limit` are all 0.
- R2: Switching starts only when `en_in` and `supply_ok` are both high. `pwm_en` rises one clock after the edge at which both are seen high in idle, and `ss_ramp` is 0 at that point.
- R3: While switching, each `tick` raises `ss_ramp` by 5, saturating at TOP = floor(5·STEPS·51/40). The regulation level 5·STEPS is reached after STEPS ticks. Clock edges without a tick leave the ramp unchanged.
- R4: `ss_done` is high exactly when `ss_ramp` is at or above TOP.
- R5: When `oc_trip` is seen high while switching, `pwm_en` stays high through the next tick and drops at the edge of the second tick. At that same edge `ss_ramp` is cleared to 0.
- R6: During the dummy ramp, `pwm_en` is 0 and each tick adds 1 to `ss_ramp`. One clock after the ramp reaches 5·STEPS (that is, after 5·STEPS ticks), a normal start begins: `ss_ramp` is 0 and `pwm_en` is 1. A new `oc_trip` repeats the hiccup.
- R7: `ov_soft` high turns all drivers off one clock later. The ramp holds its value. Switching resumes one clock after `fb_low` is seen high with `ov_soft` low.
- R8: `ov_hard` high turns all drivers off one clock later and clears the ramp. The block stays off, whatever `en_in` does, until `unlatch` is high. It then passes through idle, which takes one clock, and starts again.
- R9: `ot_hot` high stops switching one clock later. Only `ot_cool` restarts it, one clock later, with `ss_ramp` at 0.
- R10: `en_in` or `supply_ok` low stops switching and clears the ramp one clock later, from any state except the overvoltage latch. This includes the dummy ramp.
- R11: `cbc_limit` is `oc_lim` registered by one clock while switching. `oc_lim` changes neither the ramp progression nor `pwm_en`.
- R12: `hs_en` equals `pwm_en`. `ls_en` equals `pwm_en` when `LS_PRESENT` is 1 and is tied to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe per switching period |
| en_in | input | 1 | Converter enable |
| supply_ok | input | 1 | Bias supply above its power-on threshold |
| oc_lim | input | 1 | First-tier (cycle-by-cycle) overcurrent flag |
| oc_trip | input | 1 | Second-tier overcurrent flag |
| ov_soft | input | 1 | Feedback above the self-releasing overvoltage threshold |
| ov_hard | input | 1 | Feedback above the latching overvoltage threshold |
| fb_low | input | 1 | Feedback at or below the reference |
| ot_hot | input | 1 | Die temperature above the trip threshold |
| ot_cool | input | 1 | Die temperature below the recovery threshold |
| unlatch | input | 1 | Clears the overvoltage latch |
| ss_ramp | output | RAMP_W | Soft-start ramp value |
| pwm_en | output | 1 | Modulator enable |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| ss_done | output | 1 | Soft-start complete |
| cbc_limit | output | 1 | Cycle-by-cycle current-limit request |

## Verification
Every output is a register, so a fault flag, a supply change or a tick shows on the outputs after exactly one clock edge. The two-period hiccup delay and the dummy-to-normal handoff add a fixed number of ticks on top of that edge. The bench drives inputs 2 ns after a rising edge and samples at the same point after the edge it expects the result on. A tick is a single high clock followed by two idle clocks. Expected ramp values are therefore computed per tick. The dummy-ramp end can be predicted to the exact tick, with the handoff to the normal start landing one clock after the last dummy increment.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOFT,
    ST_RUN,
    ST_ARM,
    ST_DUMMY,
    ST_OVH,
    ST_OTH,
    ST_LATCH
  } seq_state_t;

  localparam int FAST_INC = 5;
  localparam int SLOW_INC = 1;

  // ramp value that corresponds to the regulation reference
  function automatic int ref_level(input int steps);
    return FAST_INC * steps;
  endfunction

  // start-complete level, about 1.275 times the reference
  function automatic int done_level(input int steps);
    return (FAST_INC * steps * 51) / 40;
  endfunction

endpackage

// File: rtl/hiccup_ramp.sv
module hiccup_ramp
  import hiccup_pkg::*;
#(
  parameter int STEPS  = 16,
  parameter int RAMP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr,
  input  logic              fast,
  input  logic              slow,
  output logic [RAMP_W-1:0] ramp,
  output logic              at_ref,
  output logic              done
);

  localparam logic [RAMP_W-1:0] REF_V  = RAMP_W'(ref_level(STEPS));
  localparam logic [RAMP_W-1:0] TOP_V  = RAMP_W'(done_level(STEPS));
  localparam logic [RAMP_W:0]   TOP_X  = (RAMP_W+1)'(done_level(STEPS));
  localparam logic [RAMP_W:0]   FAST_X = (RAMP_W+1)'(FAST_INC);
  localparam logic [RAMP_W:0]   SLOW_X = (RAMP_W+1)'(SLOW_INC);

  logic [RAMP_W:0]   inc;
  logic [RAMP_W:0]   sum;
  logic [RAMP_W-1:0] ramp_d;

  always_comb begin
    if (fast)      inc = FAST_X;
    else if (slow) inc = SLOW_X;
    else           inc = '0;
    sum = {1'b0, ramp} + inc;
    if (clr)
      ramp_d = '0;
    else if (tick && (fast || slow))
      ramp_d = (sum > TOP_X) ? TOP_V : sum[RAMP_W-1:0];
    else
      ramp_d = ramp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp <= '0;
      done <= 1'b0;
    end else begin
      ramp <= ramp_d;
      done <= (ramp_d >= TOP_V);
    end
  end

  assign at_ref = (ramp >= REF_V);

endmodule

// File: rtl/hiccup_trip_delay.sv
module hiccup_trip_delay #(
  parameter int DELAY = 2,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  input  logic tick,
  output logic expired
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = arm && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (arm && tick && !expired)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
#(
  parameter bit LS_PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  input  logic supply_ok,
  input  logic oc_lim,
  input  logic oc_trip,
  input  logic ov_soft,
  input  logic ov_hard,
  input  logic fb_low,
  input  logic ot_hot,
  input  logic ot_cool,
  input  logic unlatch,
  input  logic at_ref,
  input  logic dly_done,
  output logic ramp_clr,
  output logic ramp_fast,
  output logic ramp_slow,
  output logic dly_clr,
  output logic dly_arm,
  output logic pwm_en,
  output logic hs_en,
  output logic ls_en,
  output logic cbc_limit
);

  seq_state_t st, nxt;
  logic       run_now, run_nxt;

  assign run_now = (st == ST_SOFT) || (st == ST_RUN) || (st == ST_ARM);
  assign run_nxt = (nxt == ST_SOFT) || (nxt == ST_RUN) || (nxt == ST_ARM);
  assign dly_arm = (st == ST_ARM);

  always_comb begin
    nxt       = st;
    ramp_clr  = 1'b0;
    ramp_fast = 1'b0;
    ramp_slow = 1'b0;
    dly_clr   = 1'b0;
    if (st == ST_LATCH) begin
      ramp_clr = 1'b1;
      if (unlatch) nxt = ST_IDLE;
    end else if (!(en_in && supply_ok)) begin
      nxt      = ST_IDLE;
      ramp_clr = 1'b1;
    end else if (ov_hard) begin
      nxt      = ST_LATCH;
      ramp_clr = 1'b1;
    end else if (ov_soft) begin
      nxt      = ST_OVH;
      ramp_clr = (st == ST_DUMMY);
    end else if (ot_hot) begin
      nxt = ST_OTH;
    end else begin
      case (st)
        ST_IDLE: begin
          nxt      = ST_SOFT;
          ramp_clr = 1'b1;
        end
        ST_SOFT: begin
          ramp_fast = 1'b1;
          if (oc_trip) begin
            nxt     = ST_ARM;
            dly_clr = 1'b1;
          end else if (at_ref) begin
            nxt = ST_RUN;
          end
        end
        ST_RUN: begin
          ramp_fast = 1'b1;
          if (oc_trip) begin
            nxt     = ST_ARM;
            dly_clr = 1'b1;
          end
        end
        ST_ARM: begin
          ramp_fast = 1'b1;
          if (dly_done) begin
            nxt      = ST_DUMMY;
            ramp_clr = 1'b1;
          end
        end
        ST_DUMMY: begin
          if (at_ref) begin
            nxt      = ST_SOFT;
            ramp_clr = 1'b1;
          end else begin
            ramp_slow = 1'b1;
          end
        end
        ST_OVH: begin
          if (fb_low) nxt = ST_SOFT;
        end
        ST_OTH: begin
          if (ot_cool) begin
            nxt      = ST_SOFT;
            ramp_clr = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pwm_en    <= 1'b0;
      hs_en     <= 1'b0;
      cbc_limit <= 1'b0;
    end else begin
      st        <= nxt;
      pwm_en    <= run_nxt;
      hs_en     <= run_nxt;
      cbc_limit <= oc_lim && run_now;
    end
  end

  generate
    if (LS_PRESENT) begin : g_sync_low
      always_ff @(posedge clk) begin
        if (rst) ls_en <= 1'b0;
        else     ls_en <= run_nxt;
      end
    end else begin : g_diode_low
      assign ls_en = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_pkg::*;
#(
  parameter int STEPS      = 16,
  parameter int TRIP_DELAY = 2,
  parameter bit LS_PRESENT = 1'b1,
  localparam int RAMP_W    = $clog2(done_level(STEPS) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en_in,
  input  logic              supply_ok,
  input  logic              oc_lim,
  input  logic              oc_trip,
  input  logic              ov_soft,
  input  logic              ov_hard,
  input  logic              fb_low,
  input  logic              ot_hot,
  input  logic              ot_cool,
  input  logic              unlatch,
  output logic [RAMP_W-1:0] ss_ramp,
  output logic              pwm_en,
  output logic              hs_en,
  output logic              ls_en,
  output logic              ss_done,
  output logic              cbc_limit
);

  localparam int DLY_W = $clog2(TRIP_DELAY + 1);

  logic ramp_clr, ramp_fast, ramp_slow, at_ref;
  logic dly_clr, dly_arm, dly_done;

  hiccup_ramp #(
    .STEPS  (STEPS),
    .RAMP_W (RAMP_W)
  ) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .clr    (ramp_clr),
    .fast   (ramp_fast),
    .slow   (ramp_slow),
    .ramp   (ss_ramp),
    .at_ref (at_ref),
    .done   (ss_done)
  );

  hiccup_trip_delay #(
    .DELAY (TRIP_DELAY),
    .CNT_W (DLY_W)
  ) u_delay (
    .clk     (clk),
    .rst     (rst),
    .clr     (dly_clr),
    .arm     (dly_arm),
    .tick    (tick),
    .expired (dly_done)
  );

  hiccup_fsm #(
    .LS_PRESENT (LS_PRESENT)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en_in     (en_in),
    .supply_ok (supply_ok),
    .oc_lim    (oc_lim),
    .oc_trip   (oc_trip),
    .ov_soft   (ov_soft),
    .ov_hard   (ov_hard),
    .fb_low    (fb_low),
    .ot_hot    (ot_hot),
    .ot_cool   (ot_cool),
    .unlatch   (unlatch),
    .at_ref    (at_ref),
    .dly_done  (dly_done),
    .ramp_clr  (ramp_clr),
    .ramp_fast (ramp_fast),
    .ramp_slow (ramp_slow),
    .dly_clr   (dly_clr),
    .dly_arm   (dly_arm),
    .pwm_en    (pwm_en),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .cbc_limit (cbc_limit)
  );

endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk
  import hiccup_pkg::*;
#(
  parameter int STEPS      = 16,
  parameter bit LS_PRESENT = 1'b1,
  parameter int RAMP_W     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              en_in,
  input logic              supply_ok,
  input logic              oc_lim,
  input logic              oc_trip,
  input logic              ov_soft,
  input logic              ov_hard,
  input logic              ot_hot,
  input logic [RAMP_W-1:0] ss_ramp,
  input logic              pwm_en,
  input logic              hs_en,
  input logic              ls_en,
  input logic              ss_done,
  input logic              cbc_limit
);

  localparam logic [RAMP_W-1:0] DONE_V = RAMP_W'(done_level(STEPS));
  localparam logic [RAMP_W:0]   STEP_X = (RAMP_W+1)'(FAST_INC);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ss_ramp == '0) && !pwm_en && !ss_done && !cbc_limit); // R1

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (ss_ramp <= DONE_V) |=> (ss_ramp == '0) ||
      ((ss_ramp >= $past(ss_ramp)) &&
       ({1'b0, ss_ramp} <= {1'b0, $past(ss_ramp)} + STEP_X))); // R3

  AST_DONE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> (ss_ramp >= DONE_V)); // R4

  AST_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
    (ss_ramp >= DONE_V) |-> ss_done); // R4

  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (oc_trip && pwm_en && en_in && supply_ok && !ov_soft && !ov_hard &&
     !ot_hot && !tick) |=> pwm_en); // R5

  AST_OVSOFT_OFF: assert property (@(posedge clk) disable iff (rst)
    ov_soft |=> !pwm_en && !hs_en && !ls_en); // R7

  AST_OVHARD_OFF: assert property (@(posedge clk) disable iff (rst)
    ov_hard |=> !hs_en && !ls_en && (ss_ramp == '0)); // R8

  AST_HOT_OFF: assert property (@(posedge clk) disable iff (rst)
    ot_hot |=> !pwm_en); // R9

  AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (rst)
    !(en_in && supply_ok) |=> !pwm_en); // R10

  AST_CBC_SOURCE: assert property (@(posedge clk) disable iff (rst)
    cbc_limit |-> $past(oc_lim)); // R11

  AST_DRIVER_PAIR: assert property (@(posedge clk) disable iff (rst)
    (hs_en == pwm_en) && (ls_en == (pwm_en && LS_PRESENT))); // R12

endmodule

bind hiccup_seq hiccup_seq_chk #(
  .STEPS      (STEPS),
  .LS_PRESENT (LS_PRESENT),
  .RAMP_W     (RAMP_W)
) u_hiccup_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .en_in     (en_in),
  .supply_ok (supply_ok),
  .oc_lim    (oc_lim),
  .oc_trip   (oc_trip),
  .ov_soft   (ov_soft),
  .ov_hard   (ov_hard),
  .ot_hot    (ot_hot),
  .ss_ramp   (ss_ramp),
  .pwm_en    (pwm_en),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .ss_done   (ss_done),
  .cbc_limit (cbc_limit)
);

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;

  localparam int STEPS = 4;
  localparam int REFL  = 5 * STEPS;
  localparam int TOPL  = (REFL * 51) / 40;
  localparam int W     = $clog2(TOPL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, en_in = 1'b0, supply_ok = 1'b0;
  logic oc_lim = 1'b0, oc_trip = 1'b0, ov_soft = 1'b0, ov_hard = 1'b0;
  logic fb_low = 1'b0, ot_hot = 1'b0, ot_cool = 1'b0, unlatch = 1'b0;
  logic [W-1:0] ss_ramp;
  logic pwm_en, hs_en, ls_en, ss_done, cbc_limit;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int exp_ramp;

  always #5 clk = ~clk;

  hiccup_seq #(.STEPS(STEPS)) i_hiccup_seq (
    .clk(clk), .rst(rst), .tick(tick), .en_in(en_in), .supply_ok(supply_ok),
    .oc_lim(oc_lim), .oc_trip(oc_trip), .ov_soft(ov_soft), .ov_hard(ov_hard),
    .fb_low(fb_low), .ot_hot(ot_hot), .ot_cool(ot_cool), .unlatch(unlatch),
    .ss_ramp(ss_ramp), .pwm_en(pwm_en), .hs_en(hs_en), .ls_en(ls_en),
    .ss_done(ss_done), .cbc_limit(cbc_limit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic tk();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    cyc();
    cyc();
  endtask

  task automatic drv(input string req, input int on);
    check(req, pwm_en, on);
    check({req, "/R12 hs"}, hs_en, on);
    check({req, "/R12 ls"}, ls_en, on);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2;
    cyc(); cyc();
    check("R1 ramp", ss_ramp, 0);
    drv("R1 drivers", 0);
    check("R1 done", ss_done, 0);
    check("R1 cbc", cbc_limit, 0);
    rst = 1'b0;

    cyc(); cyc();
    drv("R2 no enable", 0);
    en_in = 1'b1;
    cyc(); cyc();
    drv("R2 no supply", 0);
    supply_ok = 1'b1;
    cyc();
    drv("R2 start", 1);
    check("R2 start ramp", ss_ramp, 0);

    // normal ramp, with the first-tier limit held over one tick
    exp_ramp = 0;
    for (int i = 1; i <= STEPS + 3; i++) begin
      oc_lim = (i == 3);
      tk();
      exp_ramp = (exp_ramp + 5 > TOPL) ? TOPL : exp_ramp + 5;
      check("R3 ramp step", ss_ramp, exp_ramp);
      check("R4 done flag", ss_done, (exp_ramp >= TOPL) ? 1 : 0);
      if (i == 3) begin
        check("R11 cbc high", cbc_limit, 1);
        drv("R11 pwm kept", 1);
      end
    end
    oc_lim = 1'b0;
    cyc();
    check("R11 cbc low", cbc_limit, 0);
    cyc();
    check("R3 no tick hold", ss_ramp, TOPL);

    // two hiccup rounds
    for (int round = 0; round < 2; round++) begin
      oc_trip = 1'b1;
      cyc();
      oc_trip = 1'b0;
      drv("R5 armed", 1);
      tk();
      drv("R5 after first tick", 1);
      tk();
      drv("R5 blanked", 0);
      check("R5 ramp cleared", ss_ramp, 0);
      for (int i = 1; i <= 5 * STEPS; i++) begin
        tk();
        if (i < 5 * STEPS) begin
          check("R6 dummy ramp", ss_ramp, i);
          check("R6 dummy pwm", pwm_en, 0);
        end else begin
          check("R6 restart ramp", ss_ramp, 0);
          drv("R6 restart", 1);
        end
      end
      for (int i = 1; i <= STEPS; i++) tk();
      check("R6 normal again", ss_ramp, REFL);
    end

    // self-releasing overvoltage
    ov_soft = 1'b1;
    cyc();
    drv("R7 off", 0);
    tk();
    check("R7 ramp held", ss_ramp, REFL);
    ov_soft = 1'b0;
    cyc();
    drv("R7 waits fb", 0);
    fb_low = 1'b1;
    cyc();
    fb_low = 1'b0;
    drv("R7 released", 1);
    check("R7 ramp kept", ss_ramp, REFL);

    // over-temperature
    ot_hot = 1'b1;
    cyc();
    ot_hot = 1'b0;
    drv("R9 off", 0);
    cyc(); cyc();
    drv("R9 waits cool", 0);
    ot_cool = 1'b1;
    cyc();
    ot_cool = 1'b0;
    drv("R9 restart", 1);
    check("R9 ramp zero", ss_ramp, 0);

    // latching overvoltage
    tk();
    check("R3 fresh step", ss_ramp, 5);
    ov_hard = 1'b1;
    cyc();
    ov_hard = 1'b0;
    drv("R8 off", 0);
    check("R8 ramp zero", ss_ramp, 0);
    en_in = 1'b0;
    cyc(); cyc();
    en_in = 1'b1;
    cyc(); cyc(); tk();
    drv("R8 stays latched", 0);
    unlatch = 1'b1;
    cyc();
    unlatch = 1'b0;
    drv("R8 via idle", 0);
    cyc();
    drv("R8 restart", 1);

    // supply loss
    tk();
    supply_ok = 1'b0;
    cyc();
    drv("R10 supply lost", 0);
    check("R10 ramp zero", ss_ramp, 0);
    supply_ok = 1'b1;
    cyc();
    drv("R10 supply back", 1);

    // enable drop during the dummy ramp
    oc_trip = 1'b1;
    cyc();
    oc_trip = 1'b0;
    tk(); tk();
    tk(); tk();
    check("R6 dummy mid", ss_ramp, 2);
    en_in = 1'b0;
    cyc();
    drv("R10 enable drop", 0);
    check("R10 ramp cleared", ss_ramp, 0);
    en_in = 1'b1;
    cyc();
    drv("R10 re-enable", 1);

    // reset mid-run
    tk();
    rst = 1'b1;
    cyc();
    check("R1 mid reset ramp", ss_ramp, 0);
    drv("R1 mid reset", 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule